// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of a multi-stream audio DMA controller into one 32-bit interrupt status word and one level-sensitive interrupt request line. Each stream reports through a status register and a control register. The controller-level sources are the response-ring status and control bits and the codec state-change flags, which are qualified by a wake-enable mask. A global control word holds the master enable, the controller-level enable and one enable per stream.

The status word is purely combinational, so a register read always sees the current state of the sources. The request line is registered. A pending source sets its bit in the status word, and the global status bit, even when its enable in the global control word is clear. Only the global enable together with the controller and stream enables can raise the line. Input streams take the low stream indices and output streams follow them. The block also exports a direction flag for each stream.

Top module: `aud_irq_agg`

## Requirements
- R1: Status bit k (k below the stream count, 8 by default) is 1 exactly when `strm_sts_i` and `strm_ctl_i` of stream k share a set bit at one of bit 2 (completion), bit 3 (FIFO error) or bit 4 (descriptor error). Each stream uses an 8-bit slice at [8k+7:8k]. Other bit positions have no effect.
- R2: Status bit 30 is 1 when `ring_sts_i & ring_ctl_i` has bit 0 (response interrupt) or bit 2 (overrun) set. Other ring bits have no effect.
- R3: Status bit 30 is also 1 when `codec_chg_i & wake_en_i` is nonzero.
- R4: Status bit 31 is 1 exactly when any of bits 30..0 of the status word is 1. It is independent of all enables.
- R5: Status bits between the stream count and bit 29 always read 0.
- R6: `irq_o` is 1 in the cycle after the inputs satisfy the following: `glb_ctl_i[31]` is 1, and the status word ANDed with `glb_ctl_i` is nonzero in bit 30 or in a stream bit. Otherwise it is 0 in that cycle.
- R7: When every enable in `glb_ctl_i` is 0, `irq_o` stays 0 even though status bit 31 may read 1. Status bit 31 never raises the line on its own.
- R8: `strm_is_out_o[k]` is 1 exactly when k is at or above the input-stream count (4 by default).
- R9: While `rst_ni` is low, `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strm_sts_i | input | 64 | Per-stream status registers, 8 bits each |
| strm_ctl_i | input | 64 | Per-stream control registers, 8 bits each |
| ring_sts_i | input | 8 | Response-ring status |
| ring_ctl_i | input | 8 | Response-ring control |
| codec_chg_i | input | 15 | Codec state-change flags |
| wake_en_i | input | 15 | Wake-enable mask for codec flags |
| glb_ctl_i | input | 32 | Global interrupt control: bit 31 master, bit 30 controller, low bits streams |
| int_sts_o | output | 32 | Computed interrupt status word |
| irq_o | output | 1 | Registered interrupt request line |
| strm_is_out_o | output | 8 | Per-stream direction flag, 1 = output |

## Verification
The assertions check on every cycle the following properties:
- The global status bit agrees with the OR of the other status bits.
- The unused status bits stay clear.
- A stream bit or the controller bit never shows without a qualifying source.
- The line falls one cycle after the master enable or all enabled sources go away.
- The line only rises after an enabled source was pending.

Only the bench scenarios can show the following:
- The exact mapping of each status and enable bit position.
- The case where the global status bit reads 1 while the line stays low.
- Source bits outside the masks being ignored.
- The one-cycle delay of the line measured against its independently computed value.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  // per-stream status/control field positions (shared by both registers)
  localparam int STRM_CMP_BIT  = 2;
  localparam int STRM_FIFO_BIT = 3;
  localparam int STRM_DESC_BIT = 4;
  // response-ring field positions
  localparam int RING_RESP_BIT = 0;
  localparam int RING_OVR_BIT  = 2;
  // status word layout
  localparam int STS_W         = 32;
  localparam int CTRL_BIT      = 30;
  localparam int GLB_BIT       = 31;
endpackage

// File: rtl/aud_irq_strm_src.sv
module aud_irq_strm_src
  import aud_irq_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic [SW-1:0] sts_i,
  input  logic [SW-1:0] ctl_i,
  output logic          pend_o
);
  logic [SW-1:0] mask;

  always_comb begin
    mask = '0;
    mask[STRM_CMP_BIT]  = 1'b1;
    mask[STRM_FIFO_BIT] = 1'b1;
    mask[STRM_DESC_BIT] = 1'b1;
  end

  assign pend_o = |(sts_i & ctl_i & mask);
endmodule

// File: rtl/aud_irq_ctrl_src.sv
module aud_irq_ctrl_src
  import aud_irq_pkg::*;
#(
  parameter int RW      = 8,
  parameter int CODEC_W = 15
) (
  input  logic [RW-1:0]      ring_sts_i,
  input  logic [RW-1:0]      ring_ctl_i,
  input  logic [CODEC_W-1:0] codec_chg_i,
  input  logic [CODEC_W-1:0] wake_en_i,
  output logic               pend_o
);
  logic [RW-1:0] ring_mask;
  logic          ring_pend, codec_pend;

  always_comb begin
    ring_mask = '0;
    ring_mask[RING_RESP_BIT] = 1'b1;
    ring_mask[RING_OVR_BIT]  = 1'b1;
  end

  assign ring_pend  = |(ring_sts_i & ring_ctl_i & ring_mask);
  assign codec_pend = |(codec_chg_i & wake_en_i);
  assign pend_o     = ring_pend | codec_pend;
endmodule

// File: rtl/aud_irq_line.sv
module aud_irq_line
  import aud_irq_pkg::*;
#(
  parameter int NS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STS_W-1:0] int_sts_i,
  input  logic [STS_W-1:0] glb_ctl_i,
  output logic             irq_o
);
  logic [STS_W-1:0] line_mask;
  logic             irq_d;

  // global status bit excluded: it must never drive the line
  always_comb begin
    line_mask = '0;
    line_mask[NS-1:0] = '1;
    line_mask[CTRL_BIT] = 1'b1;
  end

  assign irq_d = glb_ctl_i[GLB_BIT] & |(int_sts_i & glb_ctl_i & line_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= irq_d;
  end
endmodule

// File: rtl/aud_irq_agg.sv
module aud_irq_agg
  import aud_irq_pkg::*;
#(
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  parameter int SW      = 8,
  parameter int RW      = 8,
  parameter int CODEC_W = 15,
  localparam int NS     = N_IN + N_OUT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NS*SW-1:0]   strm_sts_i,
  input  logic [NS*SW-1:0]   strm_ctl_i,
  input  logic [RW-1:0]      ring_sts_i,
  input  logic [RW-1:0]      ring_ctl_i,
  input  logic [CODEC_W-1:0] codec_chg_i,
  input  logic [CODEC_W-1:0] wake_en_i,
  input  logic [STS_W-1:0]   glb_ctl_i,
  output logic [STS_W-1:0]   int_sts_o,
  output logic               irq_o,
  output logic [NS-1:0]      strm_is_out_o
);
  logic [NS-1:0] strm_pend;
  logic          ctrl_pend;
  logic [STS_W-1:0] sts_raw;

  for (genvar k = 0; k < NS; k++) begin : g_strm
    aud_irq_strm_src #(.SW(SW)) u_src (
      .sts_i  (strm_sts_i[k*SW +: SW]),
      .ctl_i  (strm_ctl_i[k*SW +: SW]),
      .pend_o (strm_pend[k])
    );
    assign strm_is_out_o[k] = (k >= N_IN);
  end

  aud_irq_ctrl_src #(.RW(RW), .CODEC_W(CODEC_W)) u_ctrl (
    .ring_sts_i  (ring_sts_i),
    .ring_ctl_i  (ring_ctl_i),
    .codec_chg_i (codec_chg_i),
    .wake_en_i   (wake_en_i),
    .pend_o      (ctrl_pend)
  );

  always_comb begin
    sts_raw = '0;
    sts_raw[NS-1:0] = strm_pend;
    sts_raw[CTRL_BIT] = ctrl_pend;
  end

  always_comb begin
    int_sts_o = sts_raw;
    int_sts_o[GLB_BIT] = |sts_raw[GLB_BIT-1:0];
  end

  aud_irq_line #(.NS(NS)) u_line (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .int_sts_i (int_sts_o),
    .glb_ctl_i (glb_ctl_i),
    .irq_o     (irq_o)
  );
endmodule

// File: rtl/aud_irq_agg_chk.sv
module aud_irq_agg_chk
  import aud_irq_pkg::*;
#(
  parameter int NS = 8,
  parameter int SW = 8,
  parameter int RW = 8,
  parameter int CODEC_W = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NS*SW-1:0]   strm_sts_i,
  input logic [NS*SW-1:0]   strm_ctl_i,
  input logic [RW-1:0]      ring_sts_i,
  input logic [RW-1:0]      ring_ctl_i,
  input logic [CODEC_W-1:0] codec_chg_i,
  input logic [CODEC_W-1:0] wake_en_i,
  input logic [STS_W-1:0]   glb_ctl_i,
  input logic [STS_W-1:0]   int_sts_o,
  input logic               irq_o
);
  logic [STS_W-1:0] en_pend;
  assign en_pend = int_sts_o & glb_ctl_i;

  assert_glb_or_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sts_o[GLB_BIT] == |int_sts_o[GLB_BIT-1:0]);

  assert_unused_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_sts_o[CTRL_BIT-1:NS] == '0);

  assert_strm_needs_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((strm_sts_i & strm_ctl_i) == '0) |-> (int_sts_o[NS-1:0] == '0));

  assert_ctrl_needs_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((ring_sts_i & ring_ctl_i) == '0) && ((codec_chg_i & wake_en_i) == '0))
      |-> !int_sts_o[CTRL_BIT]);

  assert_master_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_ctl_i[GLB_BIT] |=> !irq_o);

  assert_no_enabled_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_pend[NS-1:0] == '0 && !en_pend[CTRL_BIT]) |=> !irq_o);

  assert_rise_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(glb_ctl_i[GLB_BIT] && (en_pend[NS-1:0] != '0 || en_pend[CTRL_BIT])));
endmodule

bind aud_irq_agg aud_irq_agg_chk #(.NS(NS), .SW(SW), .RW(RW), .CODEC_W(CODEC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .strm_sts_i(strm_sts_i), .strm_ctl_i(strm_ctl_i),
  .ring_sts_i(ring_sts_i), .ring_ctl_i(ring_ctl_i), .codec_chg_i(codec_chg_i),
  .wake_en_i(wake_en_i), .glb_ctl_i(glb_ctl_i), .int_sts_o(int_sts_o), .irq_o(irq_o)
);

// File: tb/sim_aud_irq_agg.sv
`timescale 1ns/1ps
module sim_aud_irq_agg;
  localparam int NS = 8;
  localparam int SW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [63:0]   strm_sts = '0, strm_ctl = '0;
  logic [7:0]    ring_sts = '0, ring_ctl = '0;
  logic [14:0]   codec_chg = '0, wake_en = '0;
  logic [31:0]   glb_ctl = '0;
  logic [31:0]   int_sts;
  logic          irq;
  logic [7:0]    is_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aud_irq_agg u0 (
    .clk_i(clk), .rst_ni(rst_n), .strm_sts_i(strm_sts), .strm_ctl_i(strm_ctl),
    .ring_sts_i(ring_sts), .ring_ctl_i(ring_ctl), .codec_chg_i(codec_chg),
    .wake_en_i(wake_en), .glb_ctl_i(glb_ctl), .int_sts_o(int_sts), .irq_o(irq),
    .strm_is_out_o(is_out)
  );

  function automatic logic [31:0] exp_sts();
    logic [31:0] s = '0;
    for (int k = 0; k < NS; k++)
      s[k] = |(strm_sts[k*SW +: SW] & strm_ctl[k*SW +: SW] & 8'h1C);
    s[30] = |(ring_sts & ring_ctl & 8'h05) | |(codec_chg & wake_en);
    s[31] = |s[30:0];
    return s;
  endfunction

  function automatic logic exp_irq();
    logic [31:0] s = exp_sts();
    return glb_ctl[31] & |(s & glb_ctl & 32'h4000_00FF);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check status, then check line at next negedge
  task automatic step(string req);
    logic e;
    #1;
    check({req, " sts"}, int_sts, exp_sts());
    e = exp_irq();
    @(negedge clk);
    check({req, " irq"}, {31'b0, irq}, {31'b0, e});
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R9: reset holds line low even with a fully enabled source
    strm_ctl = {NS{8'h1C}}; strm_sts = {NS{8'h1C}}; glb_ctl = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    check("R9 reset irq", {31'b0, irq}, 32'h0);
    check("R8 direction", {24'b0, is_out}, 32'h0000_00F0);
    @(negedge clk); rst_n = 1'b1;
    strm_sts = '0; strm_ctl = '0; glb_ctl = '0;
    @(negedge clk);
    step("R1 idle");

    // R1: each stream and each field individually
    glb_ctl = 32'h8000_00FF;
    for (int k = 0; k < NS; k++) begin
      strm_ctl = '0; strm_sts = '0;
      strm_ctl[k*SW +: SW] = 8'h1C;
      strm_sts[k*SW +: SW] = 8'h04 << (k % 3);
      step("R1 stream field");
    end
    // R1: bits outside mask ignored
    strm_sts = {NS{8'hE3}}; strm_ctl = {NS{8'hFF}};
    step("R1 masked-out bits");
    check("R1 no stream bits", int_sts, 32'h0);

    // R2: ring sources
    strm_sts = '0; strm_ctl = '0; glb_ctl = 32'hC000_0000;
    ring_sts = 8'h01; ring_ctl = 8'h01; step("R2 resp");
    ring_sts = 8'h04; ring_ctl = 8'h04; step("R2 overrun");
    ring_sts = 8'hFA; ring_ctl = 8'hFA; step("R2 ignored bits");
    ring_sts = 8'h04; ring_ctl = 8'h01; step("R2 no overlap");
    ring_sts = '0; ring_ctl = '0;

    // R3: codec state change
    codec_chg = 15'h4000; wake_en = 15'h4000; step("R3 codec");
    check("R3 ctrl bit", int_sts, 32'hC000_0000);
    codec_chg = 15'h4000; wake_en = 15'h3FFF; step("R3 masked");

    // R7: pending but not enabled in global control: GIS=1, line low
    codec_chg = '0; wake_en = '0;
    strm_sts[5*SW +: SW] = 8'h10; strm_ctl[5*SW +: SW] = 8'h10;
    glb_ctl = 32'h8000_0000; step("R7 gis without enables");
    check("R7 gis", int_sts, 32'h8000_0020);
    check("R7 line low", {31'b0, irq}, 32'h0);
    // R6: master enable off with enabled source
    glb_ctl = 32'h4000_00FF; step("R6 master off");
    glb_ctl = 32'h8000_0020; step("R6 enabled");
    check("R6 line high", {31'b0, irq}, 32'h1);

    // random mix
    for (int i = 0; i < 300; i++) begin
      strm_sts  = {$urandom, $urandom} & {$urandom, $urandom};
      strm_ctl  = {$urandom, $urandom};
      ring_sts  = 8'($urandom); ring_ctl = 8'($urandom);
      codec_chg = 15'($urandom) & 15'($urandom);
      wake_en   = 15'($urandom) & 15'($urandom);
      glb_ctl   = $urandom;
      step("R6 R4 R5 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule